// File: doc/BRIEF.md
# Codec Serial Control Port

This block is the slave end of a four-wire serial control link for an audio converter. A host frames a 16-bit command with an active-low select line. It shifts the command in on a serial clock that never stops, and the block commits the command to a bank of configuration registers. The same frame can instead ask for a value, such as a stored setting, a peak level supplied on an input port, or the port's own status. The block then shifts that value back out on a separate data line while the host is still clocking the rest of the frame.

All four link wires are brought into the system clock domain through two-flop synchronizers and are oversampled there, so the serial clock may be unrelated to every other clock in the chip. After an asynchronous reset the registers take their defaults. A busy window then stays open until a set number of rising edges of the audio frame clock have been seen. Writes that arrive in that window are thrown away and raise a sticky error flag.

Top module: `ctl_port`

## Requirements
- R1: While reset is low and just after it is released, registers 0..NATT-1 read 0x3FF, the remaining registers read 0, `wr_err` is 0, `init_busy` is 1 and `sdo` is 0.
- R2: `init_busy` stays 1 until INIT_FRAMES rising edges of `frm_clk` have been seen after reset release. It then falls to 0 and stays there.
- R3: A frame is 16 bits, most significant bit first, sampled on rising `sck` while `cs_n` is low. Bits 15..12 are the address, bit 11 is the direction (0 write, 1 read), bit 10 is ignored, and bits 9..0 are data. Once the busy window is over, a write to an address below NREG loads that register only.
- R4: A frame is discarded when `cs_n` rises after any number of rising `sck` edges other than 16.
- R5: A write during the busy window changes no register and sets `wr_err`. `wr_err` then stays 1 until it is cleared as R6 describes.
- R6: A read of address 15 returns `wr_err` in data bit 0 and `init_busy` in bit 1, with all other bits 0. The error flag is cleared when that frame ends.
- R7: During a read frame, `sdo` presents data bits 9..0, most significant first, at the rising `sck` edges of frame bits 9..0. At all other times, including during write frames and while `cs_n` is high, `sdo` is 0.
- R8: A read of an address below NREG returns that register. Addresses 8..11 return peak inputs 0..3, taken from `peak_i` in 10-bit slices with the lowest slice first. Addresses 12..14 return 0.
- R9: A write to an address at or above NREG changes no register and does not set `wr_err`.
- R10: A read frame changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_clk | input | 1 | Audio frame clock, whose rising edges time the busy window |
| cs_n | input | 1 | Active-low frame select from the host |
| sck | input | 1 | Free-running serial clock from the host |
| sdi | input | 1 | Serial command data from the host |
| sdo | output | 1 | Serial readback data to the host |
| peak_i | input | NPEAK*DATA_W | Peak levels, one 10-bit slice per detector |
| cfg_o | output | NREG*DATA_W | Register bank contents, register 0 in the low slice |
| init_busy | output | 1 | Busy window after reset is still open |
| wr_err | output | 1 | Sticky flag for a write dropped in the busy window |

## Verification
The bench builds the block with INIT_FRAMES set to 4 and the default widths: 8 registers, 4 peak inputs and a 4-bit address. The short busy window leaves room for a rejected write and two status reads inside it, while its closing edge can still be timed exactly. The small address space lets the bench write and then read back all 16 addresses. That covers real registers, read-only peak slots, empty slots and the status word, with the reserved bit toggled along the way. Frames of 15 and 17 bits probe the length rule on either side of 16.

// File: rtl/ctl_port_pkg.sv
`timescale 1ns/1ps
package ctl_port_pkg;

  typedef enum logic {
    CMD_WRITE = 1'b0,
    CMD_READ  = 1'b1
  } cmd_e;

  // Registers below natt come up at full scale, the rest at zero.
  function automatic logic [31:0] reg_default(int idx, int natt);
    return (idx < natt) ? 32'hFFFF_FFFF : 32'h0;
  endfunction

endpackage

// File: rtl/ctl_sync.sv
`timescale 1ns/1ps
module ctl_sync #(
  parameter int          W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg1, stg2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1 <= RST;
      stg2 <= RST;
    end else begin
      stg1 <= d_i;
      stg2 <= stg1;
    end
  end

  assign q_o = stg2;

endmodule

// File: rtl/ctl_serdes.sv
`timescale 1ns/1ps
module ctl_serdes #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 10,
  localparam int HDR_W  = ADDR_W + 2,
  localparam int WORD_W = HDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              sdo,
  output logic              done,
  output logic [WORD_W-1:0] word
);

  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);

  logic              sck_q, cs_q;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] out_q, out_d;
  logic              rdm_q, rdm_d;
  logic              done_q, done_d;
  logic              rise, fall, start, stop, active;

  assign rise   = sck_s & ~sck_q;
  assign fall   = ~sck_s & sck_q;
  assign start  = cs_q & ~cs_s;
  assign stop   = ~cs_q & cs_s;
  assign active = ~cs_s;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    out_d  = out_q;
    rdm_d  = rdm_q;
    done_d = 1'b0;
    if (start) begin
      cnt_d = '0;
      rdm_d = 1'b0;
    end else if (active && rise && (cnt_q <= CNT_WORD)) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q < CNT_WORD) sh_d = {sh_q[WORD_W-2:0], sdi_s};
    end else if (active && fall) begin
      if (cnt_q == CNT_HDR) begin
        out_d = rd_data;
        rdm_d = sh_q[1];
      end else if ((cnt_q > CNT_HDR) && (cnt_q < CNT_WORD)) begin
        out_d = {out_q[DATA_W-2:0], 1'b0};
      end
    end
    if (stop) done_d = (cnt_q == CNT_WORD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      sh_q   <= '0;
      cnt_q  <= '0;
      out_q  <= '0;
      rdm_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sck_q  <= sck_s;
      cs_q   <= cs_s;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      out_q  <= out_d;
      rdm_q  <= rdm_d;
      done_q <= done_d;
    end
  end

  assign rd_addr = sh_q[HDR_W-1:2];
  assign sdo     = rdm_q & ~cs_s & out_q[DATA_W-1];
  assign done    = done_q;
  assign word    = sh_q;

endmodule

// File: rtl/ctl_init.sv
`timescale 1ns/1ps
module ctl_init #(
  parameter int INIT_FRAMES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frm_s,
  output logic busy
);

  localparam int CW = $clog2(INIT_FRAMES + 1);
  localparam logic [CW-1:0] LIM = CW'(INIT_FRAMES);

  logic          frm_q;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (frm_s && !frm_q && (cnt_q != LIM)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      frm_q <= frm_s;
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != LIM);

endmodule

// File: rtl/ctl_regfile.sv
`timescale 1ns/1ps
module ctl_regfile
  import ctl_port_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 10,
  parameter int NREG      = 8,
  parameter int NATT      = 4,
  parameter int NPEAK     = 4,
  parameter int PEAK_BASE = 8,
  parameter int STAT_ADDR = 15,
  localparam int WORD_W   = ADDR_W + 2 + DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    done,
  input  logic [WORD_W-1:0]       word,
  input  logic                    busy,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [NPEAK*DATA_W-1:0] peak_i,
  output logic [NREG*DATA_W-1:0]  cfg_o,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    err
);

  logic [ADDR_W-1:0] w_addr;
  cmd_e              w_cmd;
  logic [DATA_W-1:0] w_data;
  logic              unused_rsv;
  logic              err_d;

  assign w_addr     = word[WORD_W-1 -: ADDR_W];
  assign w_cmd      = cmd_e'(word[DATA_W+1]);
  assign w_data     = word[DATA_W-1:0];
  assign unused_rsv = word[DATA_W];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DATA_W-1:0] DFLT = DATA_W'(reg_default(g, NATT));
    logic [DATA_W-1:0] q;
    logic              we;
    assign we = done && (w_cmd == CMD_WRITE) && !busy && (w_addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= DFLT;
      else if (we) q <= w_data;
    end
    assign cfg_o[g*DATA_W +: DATA_W] = q;
  end

  always_comb begin
    err_d = err;
    if (done && (w_cmd == CMD_WRITE) && busy) err_d = 1'b1;
    else if (done && (w_cmd == CMD_READ) && (w_addr == ADDR_W'(STAT_ADDR))) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= err_d;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = cfg_o[i*DATA_W +: DATA_W];
    end
    for (int i = 0; i < NPEAK; i++) begin
      if (rd_addr == ADDR_W'(PEAK_BASE + i)) rd_data = peak_i[i*DATA_W +: DATA_W];
    end
    if (rd_addr == ADDR_W'(STAT_ADDR)) rd_data = DATA_W'({busy, err});
  end

endmodule

// File: rtl/ctl_port.sv
`timescale 1ns/1ps
module ctl_port #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 10,
  parameter int NREG        = 8,
  parameter int NATT        = 4,
  parameter int NPEAK       = 4,
  parameter int PEAK_BASE   = 8,
  parameter int STAT_ADDR   = 15,
  parameter int INIT_FRAMES = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frm_clk,
  input  logic                    cs_n,
  input  logic                    sck,
  input  logic                    sdi,
  output logic                    sdo,
  input  logic [NPEAK*DATA_W-1:0] peak_i,
  output logic [NREG*DATA_W-1:0]  cfg_o,
  output logic                    init_busy,
  output logic                    wr_err
);

  localparam int WORD_W = ADDR_W + 2 + DATA_W;

  logic [3:0]        sync_o;
  logic              frm_s, cs_s, sck_s, sdi_s;
  logic              frm_done;
  logic [WORD_W-1:0] frm_word;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  ctl_sync #(.W(4), .RST(4'b0100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({frm_clk, cs_n, sck, sdi}),
    .q_o   (sync_o)
  );

  assign {frm_s, cs_s, sck_s, sdi_s} = sync_o;

  ctl_serdes #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_serdes (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck_s   (sck_s),
    .cs_s    (cs_s),
    .sdi_s   (sdi_s),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .sdo     (sdo),
    .done    (frm_done),
    .word    (frm_word)
  );

  ctl_init #(.INIT_FRAMES(INIT_FRAMES)) u_init (
    .clk   (clk),
    .rst_n (rst_n),
    .frm_s (frm_s),
    .busy  (init_busy)
  );

  ctl_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG), .NATT(NATT),
    .NPEAK(NPEAK), .PEAK_BASE(PEAK_BASE), .STAT_ADDR(STAT_ADDR)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (frm_done),
    .word    (frm_word),
    .busy    (init_busy),
    .rd_addr (rd_addr),
    .peak_i  (peak_i),
    .cfg_o   (cfg_o),
    .rd_data (rd_data),
    .err     (wr_err)
  );

endmodule

// File: rtl/ctl_port_chk.sv
`timescale 1ns/1ps
module ctl_port_chk #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 10,
  parameter int NREG      = 8,
  parameter int STAT_ADDR = 15
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cs_n,
  input logic                   sdo,
  input logic [NREG*DATA_W-1:0] cfg_o,
  input logic                   init_busy,
  input logic                   wr_err,
  input logic                   frm_done,
  input logic [ADDR_W-1:0]      frm_addr,
  input logic                   frm_rd
);

  logic is_stat, hi_addr;
  assign is_stat = (frm_addr == ADDR_W'(STAT_ADDR));
  assign hi_addr = (32'(frm_addr) >= NREG);

  a_r2_busy_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !init_busy |=> !init_busy);

  a_r5_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && init_busy) |=> $stable(cfg_o));

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && !(frm_done && frm_rd && is_stat)) |=> wr_err);

  a_r5_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_err) |-> $past(frm_done && init_busy && !frm_rd));

  a_r6_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && frm_rd && is_stat) |=> !wr_err);

  a_r7_sdo_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !sdo);

  a_r9_high_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && !frm_rd && hi_addr) |=> $stable(cfg_o));

  a_r10_read_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && frm_rd) |=> $stable(cfg_o));

endmodule

bind ctl_port ctl_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sdo       (sdo),
  .cfg_o     (cfg_o),
  .init_busy (init_busy),
  .wr_err    (wr_err),
  .frm_done  (frm_done),
  .frm_addr  (frm_word[WORD_W-1 -: ADDR_W]),
  .frm_rd    (frm_word[DATA_W+1])
);

// File: tb/test_ctl_port.sv
`timescale 1ns/1ps
module test_ctl_port;

  localparam int DW = 10;
  localparam int NR = 8;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic sdo;
  logic [NP*DW-1:0] peak;
  logic [NR*DW-1:0] cfg;
  logic busy, err;

  int checks = 0;
  int errors = 0;
  int ecnt = 0;
  bit rel = 1'b0;
  logic [DW-1:0] m [NR];

  ctl_port #(.INIT_FRAMES(4)) i_ctl_port (
    .clk(clk), .rst_n(rst_n), .frm_clk(frm), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .peak_i(peak), .cfg_o(cfg), .init_busy(busy), .wr_err(err)
  );

  always #2.5 clk = ~clk;
  initial begin #1; forever #40 sck = ~sck; end
  initial begin #3; forever #1000 frm = ~frm; end
  always @(posedge frm) if (rel) ecnt++;

  function automatic logic [NR*DW-1:0] flat();
    logic [NR*DW-1:0] f;
    for (int i = 0; i < NR; i++) f[i*DW +: DW] = m[i];
    return f;
  endfunction

  function automatic logic [DW-1:0] peak_val(int i);
    case (i)
      0: return 10'h001;
      1: return 10'h2AA;
      2: return 10'h155;
      default: return 10'h3FF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic xfer(input logic [15:0] w, input int n, output logic [15:0] got);
    got = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge sck);
      cs_n = 1'b0;
      sdi  = (k < 16) ? w[15-k] : 1'b0;
      @(posedge sck);
      if (k < 16) got[15-k] = sdo;
    end
    @(negedge sck);
    cs_n = 1'b1;
    sdi  = 1'b0;
    repeat (2) @(negedge sck);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [15:0] cmd(int a, bit rd, bit rsv, logic [DW-1:0] d);
    return {4'(a), rd, rsv, d};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] got;
    logic [DW-1:0] e;
    for (int i = 0; i < NP; i++) peak[i*DW +: DW] = peak_val(i);
    for (int i = 0; i < NR; i++) m[i] = (i < 4) ? 10'h3FF : 10'h000;
    repeat (5) @(negedge clk);
    // R1: state while reset is held
    chk("R1 cfg in reset", 80'(cfg), 80'(flat()));
    chk("R1 busy in reset", 80'(busy), 80'd1);
    @(negedge frm);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rel = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 cfg after release", 80'(cfg), 80'(flat()));
    chk("R1 err after release", 80'(err), 80'd0);
    chk("R1 sdo after release", 80'(sdo), 80'd0);

    // R5: write inside the busy window is dropped and flagged
    xfer(cmd(2, 1'b0, 1'b0, 10'h123), 16, got);
    chk("R5 busy write dropped", 80'(cfg), 80'(flat()));
    chk("R5 err set", 80'(err), 80'd1);
    chk("R7 sdo zero on write", 80'(got), 80'd0);
    // R6: status read reports and clears
    xfer(cmd(15, 1'b1, 1'b0, 10'h000), 16, got);
    chk("R6 status busy+err", 80'(got), 80'h3);
    chk("R6 err cleared", 80'(err), 80'd0);
    xfer(cmd(15, 1'b1, 1'b0, 10'h000), 16, got);
    chk("R6 status busy only", 80'(got), 80'h2);

    // R2: busy window closes on the INIT_FRAMES-th edge
    wait (ecnt == 3);
    repeat (20) @(negedge clk);
    chk("R2 busy before last edge", 80'(busy), 80'd1);
    wait (ecnt == 4);
    repeat (20) @(negedge clk);
    chk("R2 busy after last edge", 80'(busy), 80'd0);

    // R3 / R9: write sweep over every address, reserved bit toggled
    for (int a = 0; a < 16; a++) begin
      e = DW'(a * 37 + 5);
      xfer(cmd(a, 1'b0, a[0], e), 16, got);
      if (a < NR) m[a] = e;
      chk((a < NR) ? "R3 write lands" : "R9 high write ignored", 80'(cfg), 80'(flat()));
      chk("R9 no err after init", 80'(err), 80'd0);
      chk("R7 sdo zero on write", 80'(got), 80'd0);
    end

    // R8 / R7 / R10: read sweep
    for (int a = 0; a < 16; a++) begin
      if (a < NR)                 e = m[a];
      else if (a < NR + NP)       e = peak_val(a - NR);
      else                        e = '0;
      xfer(cmd(a, 1'b1, 1'b0, 10'h000), 16, got);
      chk("R8 R7 readback", 80'(got), 80'(e));
      chk("R10 read leaves regs", 80'(cfg), 80'(flat()));
    end

    // R4: wrong-length frames are discarded
    xfer(cmd(0, 1'b0, 1'b0, 10'h0AA), 15, got);
    chk("R4 short frame dropped", 80'(cfg), 80'(flat()));
    xfer(cmd(0, 1'b0, 1'b0, 10'h0AA), 17, got);
    chk("R4 long frame dropped", 80'(cfg), 80'(flat()));
    xfer(cmd(0, 1'b0, 1'b0, 10'h0AA), 16, got);
    m[0] = 10'h0AA;
    chk("R4 R3 full frame after bad ones", 80'(cfg), 80'(flat()));
    chk("R7 sdo idle between frames", 80'(sdo), 80'd0);
    summary();
  end

endmodule